// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Burst Slot Limit

This block sits in front of one slave port of a multi-layer bus matrix. It picks one of up to twelve masters for that slave. Each slave carries its own copy, so each slave can use a different policy. The policy is either fixed priority or round robin. Each master supplies a priority value, a request line and a line that says it is in the middle of a burst.

Ownership changes only at a transfer boundary. A master whose burst is still running keeps the slave, but only until a programmable slot of cycles is used up. This caps the time that a burst of undefined length can hold the slave.

When nobody requests, round-robin mode offers three ways to park the slave: release it, leave it with the last owner, or hand it to a programmed master. Parking the slave on a master saves that master the arbitration cycle on its next access. The grant is registered, so a decision made from the inputs at one clock edge is visible after that edge.

Top module: `slot_arbiter`

## Requirements
- R1: During and right after reset, `grant` is all zero and `owner` is 0. The round-robin search starts at master 0.
- R2: `grant` has at most one bit set. When a bit is set, `owner` holds its index, and when no bit is set, `owner` is 0.
- R3: With `rr_mode`=0, the requesting master with the largest `prio` field wins. Master i's field is `prio[i*3 +: 3]`, and a larger value means higher priority. Equal values go to the lower index.
- R4: With `rr_mode`=1, the search for a winner starts at the master that follows the last winner, wrapping from 11 to 0. With all twelve masters requesting, each is granted in turn.
- R5: While the owner holds both `req` and `hold`, it keeps the grant, provided its slot has not run out.
- R6: With `slot_limit`=L>0, the slot runs out once a master has been granted for L consecutive cycles. If another master is requesting at that point, the grant moves away from the owner, even in mid-burst. If no other master is requesting and the owner still requests, it keeps the grant and starts a fresh slot.
- R7: With `slot_limit`=0, no burst is ever broken.
- R8: With no request, `grant` becomes all zero when `rr_mode`=0, or when `rr_mode`=1 and `idle_mode` is 0 or 3.
- R9: With no request, `rr_mode`=1 and `idle_mode`=1, the current grant, or its absence, is kept.
- R10: With no request, `rr_mode`=1 and `idle_mode`=2, master `park_id` is granted. A `park_id` of 12 or more gives an all-zero grant.
- R11: A change in the inputs sampled at a clock edge shows up in `grant` and `owner` after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 12 | Per-master request |
| hold | input | 12 | Per-master burst in progress (not at a transfer boundary) |
| prio | input | 36 | Per-master 3-bit priority, master i at bits i*3+2..i*3 |
| rr_mode | input | 1 | 0 fixed priority, 1 round robin |
| idle_mode | input | 2 | Idle ownership: 0/3 none, 1 last owner, 2 fixed master |
| park_id | input | 4 | Master parked on in idle mode 2 |
| slot_limit | input | 8 | Slot length in cycles, 0 disables burst breaking |
| grant | output | 12 | One-hot grant |
| owner | output | 4 | Index of the granted master |

## Verification
Slot expiry and re-arbitration can happen in the same cycle. When the owner's slot runs out, that owner is removed from the candidates, and the round-robin pointer or the priority order picks a successor in that one decision. The bench provokes this by holding every request and every hold line high with a short slot length. It judges each hand-over, and the fresh slot that follows when only the owner remains, against a cycle model built from the requirements. Randomised runs then mix slot expiry with idle parking and mode changes.

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int N  = 12,
  parameter int PW = 3,
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N-1:0]    hold,
  input  logic [N*PW-1:0] prio,
  input  logic            rr_mode,
  input  logic [1:0]      idle_mode,
  input  logic [$clog2(N)-1:0] park_id,
  input  logic [SW-1:0]   slot_limit,
  output logic [N-1:0]    grant,
  output logic [$clog2(N)-1:0] owner
);
  localparam int IW = $clog2(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  grant_q, n_grant, cand;
  logic [IW-1:0] owner_q, n_owner, fp_id, rr_id, win, ptr_q, n_ptr;
  logic [SW-1:0] cnt_q, n_cnt;
  logic [PW-1:0] best;
  logic          busy, expired, locked, fp_found, rr_found, fresh;
  int            idx;

  assign busy    = |grant_q;
  assign expired = busy && slot_limit != '0 && cnt_q >= slot_limit;
  assign locked  = busy && req[owner_q] && hold[owner_q] && !expired;
  assign cand    = expired ? (req & ~grant_q) : req;
  assign win     = rr_mode ? rr_id : fp_id;

  always_comb begin
    fp_found = 1'b0;
    fp_id    = '0;
    best     = '0;
    for (int i = 0; i < N; i++)
      if (cand[i] && (!fp_found || prio[i*PW +: PW] > best)) begin
        fp_found = 1'b1;
        best     = prio[i*PW +: PW];
        fp_id    = IW'(i);
      end
  end

  always_comb begin
    rr_found = 1'b0;
    rr_id    = '0;
    idx      = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!rr_found && cand[idx]) begin
        rr_found = 1'b1;
        rr_id    = IW'(idx);
      end
    end
  end

  always_comb begin
    n_grant = grant_q;
    n_owner = owner_q;
    n_ptr   = ptr_q;
    fresh   = 1'b0;
    if (locked) begin
      n_grant = grant_q;
    end else if (|cand) begin
      n_grant = ONE << win;
      n_owner = win;
      n_ptr   = (int'(win) == N-1) ? '0 : win + 1'b1;
    end else if (expired && req[owner_q]) begin
      fresh = 1'b1;
    end else if (rr_mode && idle_mode == 2'd1) begin
      n_grant = grant_q;
    end else if (rr_mode && idle_mode == 2'd2 && int'(park_id) < N) begin
      n_grant = ONE << park_id;
      n_owner = park_id;
    end else begin
      n_grant = '0;
      n_owner = '0;
    end
    if (n_grant == '0)                         n_cnt = '0;
    else if (fresh || !busy || n_owner != owner_q) n_cnt = SW'(1);
    else if (cnt_q != '1)                      n_cnt = cnt_q + 1'b1;
    else                                       n_cnt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      owner_q <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      grant_q <= n_grant;
      owner_q <= n_owner;
      ptr_q   <= n_ptr;
      cnt_q   <= n_cnt;
    end
  end

  assign grant = grant_q;
  assign owner = owner_q;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  assert_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q) |-> grant_q[owner_q]);
  // R5 and R7: an unlimited slot never breaks a running burst
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q && req[owner_q] && hold[owner_q] && slot_limit == '0) |=> $stable(grant_q));
  assert_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q && slot_limit != '0 && cnt_q >= slot_limit && (req & ~grant_q) != '0)
      |=> grant_q != $past(grant_q));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && (!rr_mode || idle_mode == 2'd0 || idle_mode == 2'd3)) |=> grant_q == '0);
endmodule

// File: tb/test_slot_arbiter.sv
`timescale 1ns/1ps
module test_slot_arbiter;
  localparam int N = 12;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, hold = '0;
  logic [N*PW-1:0] prio = '0;
  logic          rr_mode = 1'b0;
  logic [1:0]    idle_mode = 2'd0;
  logic [3:0]    park_id = 4'd0;
  logic [7:0]    slot_limit = 8'd0;
  logic [N-1:0]  grant;
  logic [3:0]    owner;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_grant;
  int m_owner, m_cnt, m_ptr;

  always #2.5 clk = ~clk;

  slot_arbiter i_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .hold(hold), .prio(prio),
    .rr_mode(rr_mode), .idle_mode(idle_mode), .park_id(park_id),
    .slot_limit(slot_limit), .grant(grant), .owner(owner));

  function automatic logic [N-1:0] onehot(input int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic model_reset();
    m_grant = '0; m_owner = 0; m_cnt = 0; m_ptr = 0;
  endtask

  task automatic model_step();
    bit busy, expd, lock, found, fresh;
    logic [N-1:0] cand, ng;
    int no, np, w, bestp, j;
    busy = (m_grant != '0);
    expd = busy && slot_limit != 0 && m_cnt >= int'(slot_limit);
    lock = busy && req[m_owner] && hold[m_owner] && !expd;
    cand = expd ? (req & ~m_grant) : req;
    w = 0; found = 0; bestp = -1;
    if (rr_mode) begin
      for (int k = 0; k < N; k++) begin
        j = (m_ptr + k) % N;
        if (!found && cand[j]) begin found = 1; w = j; end
      end
    end else begin
      for (int i = 0; i < N; i++)
        if (cand[i] && int'(prio[i*PW +: PW]) > bestp) begin
          bestp = int'(prio[i*PW +: PW]); w = i;
        end
    end
    ng = m_grant; no = m_owner; np = m_ptr; fresh = 0;
    if (lock) ;
    else if (cand != '0) begin ng = onehot(w); no = w; np = (w + 1) % N; end
    else if (expd && req[m_owner]) fresh = 1;
    else if (rr_mode && idle_mode == 2'd1) ;
    else if (rr_mode && idle_mode == 2'd2 && int'(park_id) < N) begin
      ng = onehot(int'(park_id)); no = int'(park_id);
    end else begin ng = '0; no = 0; end
    if (ng == '0) m_cnt = 0;
    else if (fresh || !busy || no != m_owner) m_cnt = 1;
    else if (m_cnt < 255) m_cnt = m_cnt + 1;
    m_grant = ng; m_owner = no; m_ptr = np;
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (grant !== m_grant || int'(owner) != m_owner) begin
      n_fail++;
      $display("FAIL %s: grant=%h owner=%0d expected grant=%h owner=%0d",
               tag, grant, owner, m_grant, m_owner);
    end
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic set_prio(input int i, input int v);
    prio[i*PW +: PW] = PW'(v);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    rst_n = 1'b1;

    // fixed priority
    rr_mode = 0; slot_limit = 0;
    set_prio(3, 2); set_prio(7, 5);
    req = onehot(3) | onehot(7);
    cyc("R11");
    req = onehot(2) | onehot(9);
    cyc("R3");
    set_prio(4, 6); set_prio(10, 6);
    req = onehot(4) | onehot(10) | onehot(7);
    cyc("R3");

    // idle in fixed mode releases
    req = '0; idle_mode = 2'd1;
    cyc("R8");

    // round robin sweep
    rr_mode = 1; idle_mode = 2'd0; req = '1;
    repeat (14) cyc("R4");

    // burst hold with long slot and with unlimited slot
    hold = '1; slot_limit = 8'd200;
    repeat (10) cyc("R5");
    slot_limit = 8'd0;
    repeat (30) cyc("R7");

    // slot expiry breaks bursts, then fresh slot when alone
    slot_limit = 8'd3;
    repeat (12) cyc("R6");
    req = onehot(m_owner); hold = req;
    repeat (8) cyc("R6");

    // idle ownership modes
    hold = '0; req = onehot(5);
    cyc("R4");
    req = '0; idle_mode = 2'd1;
    repeat (3) cyc("R9");
    idle_mode = 2'd2; park_id = 4'd9;
    repeat (2) cyc("R10");
    park_id = 4'd13;
    cyc("R10");
    idle_mode = 2'd3;
    cyc("R8");
    req = onehot(6);
    cyc("R4");
    req = '0; idle_mode = 2'd0;
    cyc("R8");

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if (c % 150 == 0) begin
        rr_mode    = 1'($urandom);
        idle_mode  = 2'($urandom);
        park_id    = 4'($urandom_range(0, 13));
        slot_limit = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 6));
        prio       = {$urandom, $urandom};
      end
      req  = N'($urandom) & N'($urandom);
      if ($urandom_range(0, 5) == 0) req = '0;
      hold = req & N'($urandom | $urandom);
      cyc("R2");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule